// File: doc/BRIEF.md
# Command-Strobe Interval Timer

A single interval-timer channel with a small memory-mapped register interface. It counts pulses of a tick-enable input, so it can run at any fixed rate divided down from the system clock. When the count reaches a programmable terminal value, the timer raises a pending flag. The interrupt output is that flag gated by an interrupt-enable setting.

Software starts, stops and clears the counter by writing to three separate command addresses. For these writes only the address matters; the data is ignored. Separate registers hold the repeat mode, the terminal count and the interrupt enable. A dedicated address clears the pending flag.

A read-only status word gathers the state code, the enable, mode, interrupt-enable and pending flags. The live count is readable and is also available on a dedicated output. A read is requested with valid high and write low, and the data appears on the read bus one clock later.

Top module: `cmd_interval_timer`

## Requirements
- R1: After reset, the status word (offset 0x10) reads 0x01, the count reads 0, the interrupt output is low, and the terminal count (offset 0x18) reads 0xFFFFFFFF.
- R2: Any write to offset 0x04 starts the timer and any write to offset 0x08 stops it, whatever the data. A stopped timer holds its count and its state code reads 1 (idle). A running timer's state code reads 2 (active).
- R3: While running, the count rises by exactly one on each clock with tick-enable high, and it does not change on a clock with tick-enable low.
- R4: Mode bit 0 at offset 0x0C written as 0 selects repeating operation. When the count would reach the terminal value, the pending flag is set and the count restarts at 0.
- R5: Mode bit 0 written as 1 selects single-shot operation. On reaching the terminal value, the count holds that value, pending is set and the timer stops (state idle).
- R6: The status word layout is: bits [3:0] state code, bit 4 running, bit 5 single-shot mode, bit 6 interrupt enable, bit 7 pending, and all other bits 0.
- R7: Offset 0x18 is read/write and holds the terminal count. Offset 0x14 returns the live count, and writes to it have no effect.
- R8: Writing offset 0x1C sets the interrupt enable from data bit 0. The interrupt output equals pending AND interrupt enable, and the enable does not alter the pending flag.
- R9: A write to offset 0x20 with data bit 7 set clears pending, and with bit 7 clear it does nothing. A terminal event in the same clock as a clearing write leaves pending set.
- R10: Any write to offset 0x00 clears the count and the pending flag. It leaves the terminal count, mode, interrupt enable and running state unchanged.
- R11: A terminal count of 1 in repeating mode sets pending on every tick while the count stays at 0.
- R12: Read data appears on the clock after the read request. Reads of write-only offsets (0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20) return 0 and trigger no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-rate enable pulse |
| busValid | input | 1 | Bus request valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one clock after the read request |
| countOut | output | CNT_W | Live counter value |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench targets the clock in which a terminal event coincides with a pending-clear write. A design that let the clear win would drop an interrupt there. It covers a terminal count of 1, where a design that compares the current count instead of the next one would lose an interval or never fire. It checks that a command write suppresses the tick in the same clock, that single-shot operation stops with the count held at the terminal value, and that a clear command keeps every setting. A design that reset the settings would come back with the default terminal count. Reads of command offsets are checked for having no side effect, which catches decoding that ignores the write bit.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  // register offsets; the bench and software rely on these
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_START  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STOP   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TERM   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IRQEN  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h20;

  localparam int ACK_BIT = 7;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd1,
    ST_ACTIVE = 4'd2
  } ivtState_e;

  // one-cycle command pulses from control to datapath
  typedef struct packed {
    logic doClear;
    logic doStart;
    logic doStop;
    logic doAck;
  } ivtStrobe_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              running,
  input  logic              pending,
  input  logic [CNT_W-1:0]  count,
  output ivtStrobe_t        strobe,
  output logic              modeOneShot,
  output logic              irqEnable,
  output logic [CNT_W-1:0]  termCount,
  output logic [BUS_W-1:0]  busRdata
);
  logic wrHit;
  logic rdHit;
  logic [BUS_W-1:0] statusWord;
  logic [BUS_W-1:0] readMux;
  ivtState_e stateCode;

  assign wrHit = busValid & busWrite;
  assign rdHit = busValid & ~busWrite;

  always_comb begin
    strobe         = '0;
    strobe.doClear = wrHit && (busAddr == OFF_CLEAR);
    strobe.doStart = wrHit && (busAddr == OFF_START);
    strobe.doStop  = wrHit && (busAddr == OFF_STOP);
    strobe.doAck   = wrHit && (busAddr == OFF_ACK) && busWdata[ACK_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOneShot <= 1'b0;
      irqEnable   <= 1'b0;
      termCount   <= '1;
    end else if (wrHit) begin
      case (busAddr)
        OFF_MODE:  modeOneShot <= busWdata[0];
        OFF_IRQEN: irqEnable   <= busWdata[0];
        OFF_TERM:  termCount   <= busWdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign stateCode  = running ? ST_ACTIVE : ST_IDLE;
  assign statusWord = {{(BUS_W-8){1'b0}}, pending, irqEnable, modeOneShot, running, stateCode};

  always_comb begin
    case (busAddr)
      OFF_STATUS: readMux = statusWord;
      OFF_COUNT:  readMux = BUS_W'(count);
      OFF_TERM:   readMux = BUS_W'(termCount);
      default:    readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (rdHit) busRdata <= readMux;
    else busRdata <= '0;
  end

  // R12: a read never produces a command pulse
  p_read_no_cmd_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> (strobe == '0));

  // R7: terminal count only changes through a write
  p_term_only_by_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(termCount));
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  ivtStrobe_t       strobe,
  input  logic             modeOneShot,
  input  logic [CNT_W-1:0] termCount,
  output logic             running,
  output logic             pending,
  output logic [CNT_W-1:0] count
);
  logic             anyCmd;
  logic             advance;
  logic             termHit;
  logic [CNT_W-1:0] nextCount;

  // a command in the same clock suppresses that tick
  assign anyCmd    = strobe.doClear | strobe.doStart | strobe.doStop;
  assign advance   = running & tickEn & ~anyCmd;
  assign nextCount = count + CNT_W'(1);
  assign termHit   = advance && (nextCount == termCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      pending <= 1'b0;
      count   <= '0;
    end else if (strobe.doClear) begin
      count   <= '0;
      pending <= 1'b0;
    end else begin
      if (strobe.doStart) running <= 1'b1;
      if (strobe.doStop)  running <= 1'b0;
      if (advance) begin
        if (termHit) begin
          if (modeOneShot) begin
            count   <= nextCount;
            running <= 1'b0;
          end else begin
            count <= '0;
          end
        end else begin
          count <= nextCount;
        end
      end
      // terminal event beats a clear of the pending flag
      if (termHit) pending <= 1'b1;
      else if (strobe.doAck) pending <= 1'b0;
    end
  end

  // R3: the count only moves on a tick or a clear command
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.doClear) |=> $stable(count));

  // R10: a clear command empties count and pending
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClear |=> (count == '0) && !pending);

  // R2: a stop command freezes the count and halts the timer
  p_stop_freezes_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStop |=> !running && $stable(count));

  // R5: single-shot stops at the terminal value
  p_oneshot_halts_r5: assert property (@(posedge clk) disable iff (!rstN)
    (termHit && modeOneShot) |=> !running && (count == $past(termCount)));

  // R9: a terminal event always leaves pending set
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> pending);

  // R4: repeating mode restarts at zero
  p_repeat_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (termHit && !modeOneShot) |=> (count == '0) && running);
endmodule

// File: rtl/cmd_interval_timer.sv
module cmd_interval_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic [CNT_W-1:0]  countOut,
  output logic              irqOut
);
  ivtStrobe_t       strobe;
  logic             running;
  logic             pending;
  logic             modeOneShot;
  logic             irqEnable;
  logic [CNT_W-1:0] termCount;
  logic [CNT_W-1:0] count;

  ivt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busValid   (busValid),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .running    (running),
    .pending    (pending),
    .count      (count),
    .strobe     (strobe),
    .modeOneShot(modeOneShot),
    .irqEnable  (irqEnable),
    .termCount  (termCount),
    .busRdata   (busRdata)
  );

  ivt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .strobe     (strobe),
    .modeOneShot(modeOneShot),
    .termCount  (termCount),
    .running    (running),
    .pending    (pending),
    .count      (count)
  );

  assign countOut = count;
  assign irqOut   = pending & irqEnable;

  // R8: enabling the interrupt does not disturb pending
  p_irqen_keeps_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == OFF_IRQEN && !tickEn) |=> $stable(pending));
endmodule

// File: tb/test_cmd_interval_timer.sv
`timescale 1ns/1ps
module test_cmd_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] countOut;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  longint mCount, mTc;
  bit mRun, mPend, mMode, mIe;
  bit mWr, mCmd, mAdv, mHit;
  longint mNext;

  always #4 clk = ~clk;

  cmd_interval_timer i_cmd_interval_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .countOut(countOut), .irqOut(irqOut));

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mTc = 64'hFFFF_FFFF; mRun = 0; mPend = 0; mMode = 0; mIe = 0;
    end else begin
      mWr = busValid && busWrite;
      if (mWr && busAddr == 8'h00) begin
        mCount = 0; mPend = 0;
      end else begin
        mCmd  = mWr && (busAddr == 8'h04 || busAddr == 8'h08);
        mAdv  = mRun && tickEn && !mCmd;
        mNext = (mCount + 1) % 64'h1_0000_0000;
        mHit  = mAdv && (mNext == mTc);
        if (mWr && busAddr == 8'h04) mRun = 1;
        if (mWr && busAddr == 8'h08) mRun = 0;
        if (mAdv) begin
          if (mHit) begin
            mPend = 1;
            if (mMode) begin mCount = mNext; mRun = 0; end
            else mCount = 0;
          end else mCount = mNext;
        end
        if (mWr && busAddr == 8'h20 && busWdata[7] && !mHit) mPend = 0;
      end
      if (mWr && busAddr == 8'h0C) mMode = busWdata[0];
      if (mWr && busAddr == 8'h1C) mIe = busWdata[0];
      if (mWr && busAddr == 8'h18) mTc = busWdata;
    end
  end

  function automatic logic [31:0] modelRead(logic [7:0] a);
    case (a)
      8'h10: return {24'b0, mPend, mIe, mMode, mRun, (mRun ? 4'd2 : 4'd1)};
      8'h14: return mCount[31:0];
      8'h18: return mTc[31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference (R3 count, R8 interrupt)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 live count", countOut, mCount[31:0]);
      chk("R8 irq gate", {31'b0, irqOut}, {31'b0, mPend && mIe});
    end
  end

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic [7:0] a, string req, output logic [31:0] val);
    logic [31:0] exp;
    exp = modelRead(a);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
    val = busRdata;
    chk(req, val, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h10, "R1 status after reset", v); chk("R1 status value", v, 32'h01);
    rd(8'h18, "R1 term after reset", v);   chk("R1 term value", v, 32'hFFFF_FFFF);
    chk("R1 count", countOut, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);

    // R4 repeating mode, R2 start with arbitrary data
    wr(8'h18, 5); wr(8'h1C, 1); wr(8'h0C, 0); wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h10, "R6 status while active", v); chk("R2 active code", v, 32'h52);
    tickEn = 1;
    idle(12);
    chk("R4 pending after terminal", {31'b0, irqOut}, 1);

    // R9 clear without bit 7 does nothing, with bit 7 clears
    tickEn = 0;
    wr(8'h20, 32'h7F); chk("R9 no bit7 keeps pending", {31'b0, irqOut}, 1);
    wr(8'h20, 32'h80); chk("R9 bit7 clears pending", {31'b0, irqOut}, 0);

    // R9 terminal event and clear in the same clock
    tickEn = 1;
    do @(negedge clk); while (mCount != 4);
    wr(8'h20, 32'h80);
    chk("R9 event beats clear", {31'b0, irqOut}, 1);

    // R2 stop freezes count, state idle
    wr(8'h08, 32'h0);
    held = countOut;
    idle(6);
    chk("R2 frozen count", countOut, held);
    rd(8'h10, "R2 idle status", v); chk("R2 idle code", v[3:0], 4'd1);

    // R7 write to count offset ignored
    wr(8'h14, 32'h55);
    rd(8'h14, "R7 count read", v); chk("R7 count unchanged", v, held);

    // R10 clear keeps settings
    wr(8'h00, 32'h1234);
    rd(8'h18, "R10 term kept", v); chk("R10 term value", v, 5);
    rd(8'h10, "R10 status", v); chk("R10 irqen kept, pending gone", v, 32'h41);
    chk("R10 count cleared", countOut, 0);

    // R5 single-shot
    tickEn = 0;
    wr(8'h0C, 1); wr(8'h18, 3); wr(8'h00, 0); wr(8'h04, 0);
    tickEn = 1;
    idle(6);
    tickEn = 0;
    chk("R5 count held at terminal", countOut, 3);
    rd(8'h10, "R5 status", v); chk("R5 status stopped", v, 32'hE1);

    // R11 terminal count of 1
    wr(8'h0C, 0); wr(8'h18, 1); wr(8'h00, 0); wr(8'h04, 0);
    tickEn = 1;
    @(negedge clk);
    chk("R11 count stays zero", countOut, 0);
    chk("R11 pending on first tick", {31'b0, irqOut}, 1);
    idle(4);
    tickEn = 0;

    // R8 disabling the interrupt masks the output but keeps pending
    wr(8'h1C, 0);
    chk("R8 masked irq", {31'b0, irqOut}, 0);
    rd(8'h10, "R8 status", v); chk("R8 pending still set", v[7], 1'b1);
    wr(8'h1C, 1);
    chk("R8 unmasked irq", {31'b0, irqOut}, 1);

    // R3 sparse ticks
    wr(8'h08, 0); wr(8'h18, 100); wr(8'h00, 0); wr(8'h04, 0);
    for (int i = 0; i < 30; i++) begin
      tickEn = (i % 3 == 0);
      @(negedge clk);
    end
    tickEn = 0;
    rd(8'h14, "R3 sparse count", v); chk("R3 ten ticks", v, 10);

    // R12 reads of command offsets return 0 and act on nothing
    wr(8'h08, 0);
    rd(8'h04, "R12 read start offset", v); chk("R12 zero data", v, 0);
    rd(8'h00, "R12 read clear offset", v); chk("R12 zero data clear", v, 0);
    rd(8'h0C, "R12 read mode offset", v);
    rd(8'h14, "R12 count untouched", v); chk("R12 count kept", v, 10);
    rd(8'h10, "R12 still idle", v); chk("R12 idle code", v[4:0], 5'h01);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule